// File: doc/BRIEF.md
# Low-Power State Sequencer

This block decides which clocks of a small 8-bit controller core are allowed to run. Software asks it to enter a light sleep, where the processor clock stops but timers, serial logic, interrupt logic and RAM keep their clock. Software can also ask for a deep sleep, where the oscillator itself is switched off. The block also qualifies the external reset pin against the machine-cycle grid. It drives the internal reset, and it shields internal RAM from writes while a reset is pending or active.

Time is counted in machine cycles of 12 oscillator clocks. The count comes from a divide-by-two phase flop and a six-state counter. It advances only while the oscillator enable is high, and it restarts from zero when rst_n is released. A machine-cycle boundary is the last clock of each 12. The reset pin, and the wake and exit conditions that depend on it, are sampled at these boundaries. The exception is deep sleep, which has no running grid and so reacts to the pin on any clock. When deep sleep ends, a stabilisation interval of `STAB_CYCLES` machine cycles follows before the core runs again.

Top module: `lpm_ctrl`

## Requirements
- R1: The internal reset asserts only when rst_pin is sampled high at two consecutive machine-cycle boundaries, which come every 12 clocks. A high pulse that covers only one boundary leaves int_rst low.
- R2: In the run state, an idle_req pulse makes cpu_clk_en low on the next clock, while per_clk_en and osc_en stay high.
- R3: In idle, an irq_pend with rst_pin low returns the block to run on the next clock: cpu_clk_en goes high and ram_wr_inhibit stays low.
- R4: In the run state, a pdown_req makes osc_en, cpu_clk_en and per_clk_en all low on the next clock. It wins over an idle_req given in the same cycle.
- R5: In power-down, irq_pend, idle_req and pdown_req have no effect and all enables stay low. rst_pin high on any clock asserts int_rst and osc_en on the next clock.
- R6: When rst_pin is sampled high at a boundary during idle, the processor clock restarts at once with ram_wr_inhibit high. The internal reset follows at the next boundary if the pin is still high. If the pin is low at that boundary, the block returns to run with the inhibit cleared. Software requests are ignored in this window.
- R7: While int_rst is high, ram_wr_inhibit is high and the oscillator runs. After a reset that did not come from power-down, int_rst drops at the first boundary where rst_pin is sampled low, and the block enters run.
- R8: After a reset that ended power-down, int_rst stays high for STAB_CYCLES further machine cycles after the pin is sampled low, with cpu_clk_en and per_clk_en low and osc_en high. Then the block enters run. The pin seen high again at a boundary in this interval restarts the reset.
- R9: While rst_n is low, int_rst, ram_wr_inhibit, osc_en, cpu_clk_en and per_clk_en are all high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin | input | 1 | External reset pin, active high, synchronous |
| idle_req | input | 1 | Software request for idle, one-clock pulse |
| pdown_req | input | 1 | Software request for power-down, one-clock pulse |
| irq_pend | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral, timer and interrupt clock enable |
| osc_en | output | 1 | Oscillator run enable |
| int_rst | output | 1 | Internal reset |
| ram_wr_inhibit | output | 1 | Blocks writes to internal RAM |

## Verification
Requests and interrupts take effect on the first clock edge after they are seen. Anything that depends on rst_pin outside power-down is due at the edge that closes a 12-clock machine cycle. So a reset can take between one and two machine cycles to appear, depending on where in the cycle the pin rises. The bench keeps its own oscillator count modulo 12, frozen while the oscillator is off. On every rising edge it advances a behavioural state model, and at the following falling edge it compares all five outputs, so each result is checked in exactly the cycle it is due. Directed checks add bounds on the reset delay, a single-boundary pulse, priority of power-down over idle, and immunity in power-down.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [2:0] {
      PM_RUN    = 3'd0,
      PM_IDLE   = 3'd1,
      PM_RSTWIN = 3'd2,
      PM_PDOWN  = 3'd3,
      PM_RESET  = 3'd4,
      PM_STAB   = 3'd5
   } pm_state_e;
endpackage

// File: rtl/lpm_timebase.sv
// Machine-cycle grid: divide-by-two phase flop feeding a state counter.
module lpm_timebase #(
   parameter int unsigned STATES_PER_MC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mc_tick
);
   localparam int unsigned SW = (STATES_PER_MC > 1) ? $clog2(STATES_PER_MC) : 1;
   localparam logic [SW-1:0] LAST = SW'(STATES_PER_MC - 1);

   if (STATES_PER_MC < 1) begin : g_bad_states
      $error("lpm_timebase: STATES_PER_MC must be at least 1");
   end

   logic          phase_q;
   logic [SW-1:0] state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         state_q <= '0;
      end else if (run) begin
         phase_q <= ~phase_q;
         if (phase_q) begin
            state_q <= (state_q == LAST) ? '0 : state_q + SW'(1);
         end
      end
   end

   assign mc_tick = run & phase_q & (state_q == LAST);

   // R1
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mc_tick |=> !mc_tick);
endmodule

// File: rtl/lpm_rst_qual.sv
// Counts consecutive boundaries with the reset pin high.
module lpm_rst_qual #(
   parameter int unsigned QUAL_MC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mc_tick,
   input  logic rst_pin,
   output logic rst_seen
);
   localparam int unsigned QW = $clog2(QUAL_MC + 1);
   localparam logic [QW-1:0] TOP = QW'(QUAL_MC - 1);

   if (QUAL_MC < 1) begin : g_bad_qual
      $error("lpm_rst_qual: QUAL_MC must be at least 1");
   end

   logic [QW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (mc_tick) begin
         if (!rst_pin)          run_q <= '0;
         else if (run_q != TOP) run_q <= run_q + QW'(1);
      end
   end

   assign rst_seen = mc_tick & rst_pin & (run_q == TOP);

   // R1
   qual_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= TOP);
endmodule

// File: rtl/lpm_stab_timer.sv
// Counts machine cycles of oscillator settling; a zero limit removes the counter.
module lpm_stab_timer #(
   parameter int unsigned STAB_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic mc_tick,
   output logic done
);
   if (STAB_CYCLES == 0) begin : g_none
      assign done = 1'b1;
   end else begin : g_count
      localparam int unsigned CW = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
      localparam logic [CW-1:0] LIM = CW'(STAB_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cnt_q <= '0;
         else if (!active)  cnt_q <= '0;
         else if (mc_tick && cnt_q != LIM) cnt_q <= cnt_q + CW'(1);
      end

      assign done = active & mc_tick & (cnt_q == LIM);

      // R8
      stab_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LIM);
   end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int unsigned STATES_PER_MC = 6,
   parameter int unsigned QUAL_MC       = 2,
   parameter int unsigned STAB_CYCLES   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_pin,
   input  logic idle_req,
   input  logic pdown_req,
   input  logic irq_pend,
   output logic cpu_clk_en,
   output logic per_clk_en,
   output logic osc_en,
   output logic int_rst,
   output logic ram_wr_inhibit
);
   localparam bit HAS_STAB = (STAB_CYCLES != 0);

   pm_state_e state_q, state_d;
   logic      from_pd_q, from_pd_d;
   logic      mc_tick, rst_seen, stab_done;

   lpm_timebase #(.STATES_PER_MC(STATES_PER_MC)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(osc_en), .mc_tick(mc_tick));

   lpm_rst_qual #(.QUAL_MC(QUAL_MC)) u_qual (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .rst_pin(rst_pin),
      .rst_seen(rst_seen));

   lpm_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
      .clk(clk), .rst_n(rst_n), .active(state_q == PM_STAB),
      .mc_tick(mc_tick), .done(stab_done));

   always_comb begin
      state_d   = state_q;
      from_pd_d = from_pd_q;
      unique case (state_q)
         PM_RUN: begin
            if (rst_seen)       state_d = PM_RESET;
            else if (pdown_req) state_d = PM_PDOWN;
            else if (idle_req)  state_d = PM_IDLE;
         end
         PM_IDLE: begin
            if (rst_seen)                state_d = PM_RESET;
            else if (mc_tick && rst_pin) state_d = PM_RSTWIN;
            else if (irq_pend)           state_d = PM_RUN;
         end
         PM_RSTWIN: begin
            if (rst_seen)                 state_d = PM_RESET;
            else if (mc_tick && !rst_pin) state_d = PM_RUN;
         end
         PM_PDOWN: begin
            if (rst_pin) begin
               state_d   = PM_RESET;
               from_pd_d = 1'b1;
            end
         end
         PM_RESET: begin
            if (mc_tick && !rst_pin) begin
               if (from_pd_q && HAS_STAB) begin
                  state_d = PM_STAB;
               end else begin
                  state_d   = PM_RUN;
                  from_pd_d = 1'b0;
               end
            end
         end
         PM_STAB: begin
            if (mc_tick && rst_pin) begin
               state_d = PM_RESET;
            end else if (stab_done) begin
               state_d   = PM_RUN;
               from_pd_d = 1'b0;
            end
         end
         default: state_d = PM_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PM_RESET;
         from_pd_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         from_pd_q <= from_pd_d;
      end
   end

   always_comb begin
      osc_en         = (state_q != PM_PDOWN);
      cpu_clk_en     = (state_q == PM_RUN) || (state_q == PM_RSTWIN) || (state_q == PM_RESET);
      per_clk_en     = (state_q != PM_PDOWN) && (state_q != PM_STAB);
      int_rst        = (state_q == PM_RESET) || (state_q == PM_STAB);
      ram_wr_inhibit = (state_q == PM_RSTWIN) || int_rst;
   end

   // R4
   pdown_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_RUN && pdown_req && !rst_seen) |=> (!osc_en && !cpu_clk_en && !per_clk_en));

   // R5
   pdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en && !rst_pin) |=> !osc_en);

   // R3
   idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_IDLE && irq_pend && !rst_pin) |=> (cpu_clk_en && !ram_wr_inhibit));

   // R7
   rst_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_rst |-> (ram_wr_inhibit && osc_en));

   // R8
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_rst) |-> (cpu_clk_en && per_clk_en && !ram_wr_inhibit));
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
   localparam int MC   = 12;
   localparam int QUAL = 2;
   localparam int STAB = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rst_pin = 1'b0, idle_req = 1'b0, pdown_req = 1'b0, irq_pend = 1'b0;
   logic cpu_clk_en, per_clk_en, osc_en, int_rst, ram_wr_inhibit;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   lpm_ctrl #(.STATES_PER_MC(6), .QUAL_MC(QUAL), .STAB_CYCLES(STAB)) u_dut (
      .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .idle_req(idle_req),
      .pdown_req(pdown_req), .irq_pend(irq_pend), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .osc_en(osc_en), .int_rst(int_rst),
      .ram_wr_inhibit(ram_wr_inhibit));

   // behavioural model: 0 run, 1 idle, 2 reset window, 3 power-down, 4 reset, 5 settle
   int m_st = 4, m_div = 0, m_run = 0, m_sc = 0;
   bit m_pd = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 4; m_div = 0; m_run = 0; m_sc = 0; m_pd = 0;
      end else begin
         automatic bit going = (m_st != 3);
         automatic bit tk    = going && (m_div == MC - 1);
         automatic bit seen  = tk && rst_pin && (m_run == QUAL - 1);
         automatic int nx    = m_st;
         case (m_st)
            0: if (seen) nx = 4; else if (pdown_req) nx = 3; else if (idle_req) nx = 1;
            1: if (seen) nx = 4; else if (tk && rst_pin) nx = 2; else if (irq_pend) nx = 0;
            2: if (seen) nx = 4; else if (tk && !rst_pin) nx = 0;
            3: if (rst_pin) begin nx = 4; m_pd = 1; end
            4: if (tk && !rst_pin) begin
                  if (m_pd) begin nx = 5; m_sc = 0; end
                  else nx = 0;
               end
            5: if (tk && rst_pin) nx = 4;
               else if (tk) begin
                  if (m_sc == STAB - 1) begin nx = 0; m_pd = 0; end
                  else m_sc++;
               end
            default: nx = 4;
         endcase
         if (tk) m_run = rst_pin ? ((m_run < QUAL - 1) ? m_run + 1 : m_run) : 0;
         if (going) m_div = (m_div + 1) % MC;
         if (nx != 5) m_sc = 0;
         m_st = nx;
      end
   end

   function automatic string tag_of(int s);
      case (s)
         0: return "R3";
         1: return "R2";
         2: return "R6";
         3: return "R4";
         4: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string req, logic [4:0] act, logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {cpu,per,osc,rst,inh} actual %b expected %b at cycle %0d",
                  req, act, exp, cycles);
      end
   endtask

   function automatic logic [4:0] model_out(int s);
      case (s)
         0: return 5'b11100;
         1: return 5'b01100;
         2: return 5'b11101;
         3: return 5'b00000;
         4: return 5'b11111;
         default: return 5'b00111;
      endcase
   endfunction

   // every-clock comparison against the model
   always @(negedge clk) begin
      cycles++;
      check(rst_n ? tag_of(m_st) : "R9",
            {cpu_clk_en, per_clk_en, osc_en, int_rst, ram_wr_inhibit}, model_out(m_st));
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_idle();  idle_req = 1; step(1); idle_req = 0; endtask
   task automatic pulse_irq();   irq_pend = 1; step(1); irq_pend = 0; endtask

   initial begin : watchdog
      wait (cycles > 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      bit saw;
      step(3);
      // R9 reset state
      check("R9", {cpu_clk_en, per_clk_en, osc_en, int_rst, ram_wr_inhibit}, 5'b11111);
      rst_n = 1;
      step(14);
      check("R7", {int_rst, cpu_clk_en}, 2'b01);

      // R2 idle, R3 wake
      pulse_idle();
      check("R2", {cpu_clk_en, per_clk_en, osc_en}, 3'b011);
      step(20);
      pulse_irq();
      check("R3", {cpu_clk_en, ram_wr_inhibit}, 2'b10);
      step(5);

      // R1 pulse spanning one boundary only
      rst_pin = 1; saw = 0;
      for (int i = 0; i < 12; i++) begin step(1); saw |= int_rst; end
      rst_pin = 0;
      for (int i = 0; i < 30; i++) begin step(1); saw |= int_rst; end
      check("R1", {7'b0, saw}, 8'b0);

      // R1 qualified reset delay between one and two machine cycles
      step(5);
      rst_pin = 1; n = 0;
      while (!int_rst && n < 40) begin step(1); n++; end
      check("R1", {7'b0, (n >= 12 && n <= 24)}, 8'b1);
      step(10);
      rst_pin = 0;
      step(15);
      check("R7", {int_rst, cpu_clk_en}, 2'b01);

      // R6 reset ending idle, held long enough
      pulse_idle(); step(7);
      rst_pin = 1;
      step(40);
      check("R6", {int_rst, ram_wr_inhibit}, 2'b11);
      rst_pin = 0; step(15);

      // R6 reset ending idle, released after one boundary
      pulse_idle(); step(3);
      rst_pin = 1; n = 0;
      while (cpu_clk_en === 1'b0 && n < 20) begin step(1); n++; end
      check("R6", {cpu_clk_en, ram_wr_inhibit, int_rst}, 3'b110);
      rst_pin = 0; pulse_idle(); pulse_irq();
      step(14);
      check("R6", {cpu_clk_en, ram_wr_inhibit, int_rst}, 3'b100);

      // R4 priority of power-down over idle
      idle_req = 1; pdown_req = 1; step(1); idle_req = 0; pdown_req = 0;
      check("R4", {cpu_clk_en, per_clk_en, osc_en}, 3'b000);

      // R5 immunity while asleep
      saw = 0;
      for (int i = 0; i < 40; i++) begin
         irq_pend = (i % 3 == 0); idle_req = (i == 10); pdown_req = (i == 20);
         step(1); saw |= osc_en | cpu_clk_en | per_clk_en | int_rst;
      end
      irq_pend = 0; idle_req = 0; pdown_req = 0;
      step(1); saw |= osc_en;
      check("R5", {7'b0, saw}, 8'b0);
      rst_pin = 1; step(1);
      check("R5", {int_rst, osc_en}, 2'b11);

      // R8 settle after power-down
      step(18); rst_pin = 0;
      n = 0;
      while (int_rst && n < 200) begin step(1); n++; end
      check("R8", {7'b0, (n > STAB * MC && n <= (STAB + 1) * MC)}, 8'b1);
      step(5);
      check("R8", {cpu_clk_en, per_clk_en, int_rst}, 3'b110);

      // R8 pin seen again during settling restarts reset
      pdown_req = 1; step(1); pdown_req = 0; step(4);
      rst_pin = 1; step(3); rst_pin = 0;
      n = 0;
      while (per_clk_en && n < 40) begin step(1); n++; end
      step(14); rst_pin = 1; step(13);
      check("R8", {int_rst, per_clk_en}, 2'b11);
      rst_pin = 0; step(80);
      check("R8", {int_rst, cpu_clk_en}, 2'b01);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule